// File: doc/BRIEF.md
# Shared Interrupt Line Distributor

This block takes a small set of shared external interrupt lines and steers each one to the interrupt inputs of one or more processor cores. Each shared line has its own configuration: a core-select bit mask, a mode word and a mask bit. Software sets these through a command port with an opcode, a line number and a data word. Read commands return the stored settings on a readback port. Nothing reaches any core until a global enable command has been issued.

The mode word chooses one of two delivery policies. In fixed delivery, the line drives every selected core at once. In rotating delivery, each new assertion goes to exactly one selected core, and the recipient advances through the selected cores in turn. The trigger type is either level or rising edge. On each core, shared line i lands on core-side interrupt input 24+i.

Top module: `shared_irq_distributor`

## Requirements
- R1: After reset every line is masked, every core-select mask is zero, every mode word reads back as 0x10, the unit is disabled and all outputs are low.
- R2: Commands are sampled on a clock edge when `cmd_valid_i` is high. The opcodes are 0x41 set core-select, 0x42 set mode, 0x43 set mask, 0x44 enable, 0x51 read core-select, 0x52 read mode and 0x53 read mask. `cmd_param_i` is the line number. A write to a line number of 8 or more changes nothing, and a read of such a line returns 0.
- R3: In the set core-select data word, bit c selects core c. A later read core-select returns those 4 bits, zero-extended.
- R4: In the mode word, bits [1:0] hold the policy and bit 4 holds the trigger type, where 1 means level and 0 means rising edge. Policy 00 is rotating; policies 10, 01 and 11 all deliver as fixed. Reading the mode back returns bits [3:2] and bits 31:5 as zero.
- R5: A set-mask command with data bit 0 set to 1 masks the line, and 0 unmasks it. A masked line drives no output.
- R6: No output is driven until the enable command has been accepted. Once set, the enable stays set until reset.
- R7: Output bit `c*8+i` is shared line i as seen by core c, which is core-side input 24+i.
- R8: In fixed delivery, an unmasked, level-triggered line that is held high drives the outputs of all selected cores, and keeps driving them for as long as it stays high.
- R9: In rotating delivery, each new assertion goes to the next selected core after the last recipient, wrapping from core 3 to core 0. The first pick after reset starts from core 0. The chosen core keeps the line until the input drops.
- R10: With edge trigger, each rising edge of the input gives a one-cycle output pulse. An input that stays high gives no further pulse. In rotating delivery, each pulse counts as a new assertion.
- R11: A line whose core-select mask is zero delivers nothing, and its rotation pointer does not move.
- R12: Outputs follow an input or configuration change one cycle after it has been registered. Readback data is valid the cycle after the read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 8 | Command opcode |
| cmd_param_i | input | 8 | Shared line number |
| cmd_data_i | input | 32 | Command data word |
| rdata_o | output | 32 | Readback of the last read command |
| irq_i | input | 8 | Shared interrupt lines, already synchronous |
| core_irq_o | output | 32 | Per-core outputs, bit c*8+i is line i for core c |

## Verification
A command is captured on the rising edge under its strobe, so readback is compared at the falling edge that follows. An interrupt input driven at a falling edge appears on the outputs after the next rising edge, and the bench compares it at the falling edge one cycle later. After a mask or mode change with the input already high, the bench waits one idle cycle before it compares, because the configuration registers sit ahead of the output register. For rotating delivery the bench keeps its own last-recipient index for each line. It checks both the cycle of the pick and the cycles that follow while the line is held.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int OP_W   = 8;
  localparam int PAR_W  = 8;
  localparam int DATA_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 8'h00,
    OP_SET_SEL  = 8'h41,
    OP_SET_MODE = 8'h42,
    OP_SET_MASK = 8'h43,
    OP_ENABLE   = 8'h44,
    OP_RD_SEL   = 8'h51,
    OP_RD_MODE  = 8'h52,
    OP_RD_MASK  = 8'h53
  } sid_op_e;

  localparam logic [1:0] POL_ROTATE = 2'b00;
  localparam int         MODE_TRIG_BIT = 4;
endpackage

// File: rtl/sid_cfg.sv
module sid_cfg
  import sid_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int N_CORES = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cmd_valid_i,
  input  logic [OP_W-1:0]                   cmd_op_i,
  input  logic [PAR_W-1:0]                  cmd_param_i,
  input  logic [DATA_W-1:0]                 cmd_data_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              en_o,
  output logic [N_LINES-1:0]                mask_o,
  output logic [N_LINES-1:0]                lvl_o,
  output logic [N_LINES-1:0]                rot_o,
  output logic [N_LINES-1:0][N_CORES-1:0]   sel_o
);
  localparam int IDX_W = $clog2(N_LINES);
  localparam logic [PAR_W-1:0] LIM = PAR_W'(N_LINES);

  logic [N_LINES-1:0][1:0]         pol_q;
  logic [N_LINES-1:0]              lvl_q, mask_q;
  logic [N_LINES-1:0][N_CORES-1:0] sel_q;
  logic                            en_q;
  logic [DATA_W-1:0]               rdata_q;

  logic             hit;
  logic [IDX_W-1:0] idx;
  assign hit = cmd_param_i < LIM;
  assign idx = cmd_param_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= '0;
      lvl_q   <= '1;
      mask_q  <= '1;
      sel_q   <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else if (cmd_valid_i) begin
      unique case (cmd_op_i)
        OP_SET_SEL:  if (hit) sel_q[idx] <= cmd_data_i[N_CORES-1:0];
        OP_SET_MODE: if (hit) begin
          pol_q[idx] <= cmd_data_i[1:0];
          lvl_q[idx] <= cmd_data_i[MODE_TRIG_BIT];
        end
        OP_SET_MASK: if (hit) mask_q[idx] <= cmd_data_i[0];
        OP_ENABLE:   en_q <= 1'b1;
        OP_RD_SEL:   rdata_q <= hit ? {{(DATA_W-N_CORES){1'b0}}, sel_q[idx]} : '0;
        OP_RD_MODE:  rdata_q <= hit ? {{(DATA_W-5){1'b0}}, lvl_q[idx], 2'b00, pol_q[idx]} : '0;
        OP_RD_MASK:  rdata_q <= hit ? {{(DATA_W-1){1'b0}}, mask_q[idx]} : '0;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < N_LINES; i++) rot_o[i] = (pol_q[i] == POL_ROTATE);
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign lvl_o   = lvl_q;
  assign sel_o   = sel_q;

  // R6: enable is sticky
  a_r6_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
  // R5: a mask write lands in the addressed line
  a_r5_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SET_MASK && hit) |=> mask_o[$past(idx)] == $past(cmd_data_i[0]));
  // R2: out-of-range line read returns zero
  a_r2_oob_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_RD_SEL && !hit) |=> rdata_o == '0);
endmodule

// File: rtl/sid_line.sv
module sid_line #(
  parameter int N_CORES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               mask_i,
  input  logic               lvl_i,
  input  logic               rot_i,
  input  logic [N_CORES-1:0] sel_i,
  input  logic               irq_i,
  output logic [N_CORES-1:0] core_o
);
  localparam int IW = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic               irq_q, act_q, own_q;
  logic [IW-1:0]      last_q;
  logic [N_CORES-1:0] out_q;

  // first selected core strictly after 'last', wrapping
  function automatic logic [IW:0] next_pick(input logic [IW-1:0] last,
                                            input logic [N_CORES-1:0] sel);
    logic [IW:0] r;
    r = '0;
    for (int k = N_CORES; k >= 1; k--) begin
      int j;
      j = (int'(last) + k) % N_CORES;
      if (sel[IW'(j)]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  logic               live, fresh, found, own_ok;
  logic [IW-1:0]      pick_idx, owner;
  logic [N_CORES-1:0] rot_vec, nxt;

  assign live  = en_i & ~mask_i & (lvl_i ? irq_i : (irq_i & ~irq_q));
  assign fresh = live & ~act_q;
  assign {found, pick_idx} = next_pick(last_q, sel_i);
  assign owner   = fresh ? pick_idx : last_q;
  assign own_ok  = fresh ? found : own_q;
  assign rot_vec = own_ok ? (N_CORES'(1) << owner) : '0;

  always_comb begin
    if (!live)      nxt = '0;
    else if (rot_i) nxt = rot_vec & sel_i;
    else            nxt = sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      act_q  <= 1'b0;
      own_q  <= 1'b0;
      last_q <= IW'(N_CORES - 1);
      out_q  <= '0;
    end else begin
      irq_q <= irq_i;
      act_q <= live;
      own_q <= fresh ? found : (live & own_q);
      if (fresh && found && rot_i) last_q <= pick_idx;
      out_q <= nxt;
    end
  end

  assign core_o = out_q;

  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> core_o == '0);
  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> core_o == '0);
  a_r9_rot_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_i |=> $onehot0(core_o));
  a_r8_within_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (core_o & ~$past(sel_i)) == '0);
  a_r10_edge_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && irq_i && $past(irq_i)) |=> core_o == '0);
endmodule

// File: rtl/shared_irq_distributor.sv
module shared_irq_distributor
  import sid_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int N_CORES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [7:0]                 cmd_op_i,
  input  logic [7:0]                 cmd_param_i,
  input  logic [31:0]                cmd_data_i,
  output logic [31:0]                rdata_o,
  input  logic [N_LINES-1:0]         irq_i,
  output logic [N_CORES*N_LINES-1:0] core_irq_o
);
  logic                            en;
  logic [N_LINES-1:0]              mask, lvl, rot;
  logic [N_LINES-1:0][N_CORES-1:0] sel;
  logic [N_LINES-1:0][N_CORES-1:0] line_out;

  sid_cfg #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_cfg (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_param_i, .cmd_data_i,
    .rdata_o, .en_o(en), .mask_o(mask), .lvl_o(lvl), .rot_o(rot), .sel_o(sel)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    sid_line #(.N_CORES(N_CORES)) u_line (
      .clk_i, .rst_ni, .en_i(en), .mask_i(mask[i]), .lvl_i(lvl[i]),
      .rot_i(rot[i]), .sel_i(sel[i]), .irq_i(irq_i[i]), .core_o(line_out[i])
    );
    // R7: core c sees line i at bit c*N_LINES+i
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign core_irq_o[c*N_LINES+i] = line_out[i][c];
    end
  end
endmodule

// File: tb/shared_irq_distributor_tb.sv
`timescale 1ns/1ps
module shared_irq_distributor_tb;
  localparam int NL = 8;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0, cmd_param = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] rdata;
  logic [NL-1:0] irq = '0;
  logic [NC*NL-1:0] core_irq;

  int n_chk = 0, n_bad = 0;
  int last_idx [NL];

  always #5 clk = ~clk;

  shared_irq_distributor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_param_i(cmd_param), .cmd_data_i(cmd_data), .rdata_o(rdata),
    .irq_i(irq), .core_irq_o(core_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic do_cmd(input logic [7:0] op, input logic [7:0] p, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_param = p; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00;
  endtask

  task automatic drive(input logic [NL-1:0] v);
    irq = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] place(input int line, input logic [NC-1:0] cores);
    logic [31:0] r;
    r = '0;
    for (int c = 0; c < NC; c++) r[c*NL+line] = cores[c];
    return r;
  endfunction

  function automatic int pick(input int last, input logic [NC-1:0] s);
    for (int k = 1; k <= NC; k++) begin
      int j;
      j = (last + k) % NC;
      if (s[j]) return j;
    end
    return -1;
  endfunction

  // rotating assertion on one line, checked against the model
  task automatic rot_hit(input int line, input logic [NC-1:0] s);
    int p;
    logic [NC-1:0] e;
    p = pick(last_idx[line], s);
    e = '0;
    if (p >= 0) begin e[p] = 1'b1; last_idx[line] = p; end
    drive(NL'(1) << line);
    chk("R9 rotate pick", core_irq, place(line, e));
    drive(NL'(1) << line);
    chk("R9 rotate held", core_irq, place(line, e));
    drive('0);
    chk("R9 rotate drop", core_irq, '0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) last_idx[i] = NC - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs low", core_irq, '0);
    for (int i = 0; i < NL; i++) begin
      do_cmd(8'h53, 8'(i), 0); chk("R1 mask reset", rdata, 32'h1);
      do_cmd(8'h51, 8'(i), 0); chk("R1 sel reset", rdata, 32'h0);
      do_cmd(8'h52, 8'(i), 0); chk("R1 mode reset R12", rdata, 32'h10);
    end

    // R6 nothing before enable
    do_cmd(8'h41, 8'd0, 32'hF);
    do_cmd(8'h42, 8'd0, 32'h12);
    do_cmd(8'h43, 8'd0, 32'h0);
    drive('1); drive('1);
    chk("R6 disabled quiet", core_irq, '0);
    drive('0);
    do_cmd(8'h44, 8'd0, 32'h0);
    drive('1);
    chk("R6 enabled delivers", core_irq, place(0, 4'hF));
    drive('0);

    // R2 out-of-range line numbers
    do_cmd(8'h43, 8'd8, 32'h0);
    do_cmd(8'h41, 8'd200, 32'hF);
    do_cmd(8'h51, 8'd8, 0); chk("R2 oob read", rdata, 32'h0);
    do_cmd(8'h53, 8'd1, 0); chk("R2 oob write ignored", rdata, 32'h1);
    drive(8'h02); drive(8'h02);
    chk("R2 line1 still masked", core_irq, '0);
    drive('0);

    // R4 reserved bits and alias policies
    do_cmd(8'h42, 8'd3, 32'hFFFF_FFFF);
    do_cmd(8'h52, 8'd3, 0); chk("R4 mode readback", rdata, 32'h13);
    do_cmd(8'h41, 8'd3, 32'h5);
    do_cmd(8'h43, 8'd3, 32'h0);
    drive(8'h08); chk("R4 policy 11 fixed", core_irq, place(3, 4'h5));
    drive('0);
    do_cmd(8'h42, 8'd3, 32'h11);
    drive(8'h08); chk("R4 policy 01 fixed", core_irq, place(3, 4'h5));
    drive('0);

    // R8 R7 R3 fixed delivery sweep over every line and core-select mask
    for (int i = 0; i < NL; i++) begin
      do_cmd(8'h42, 8'(i), 32'h12);
      do_cmd(8'h43, 8'(i), 32'h0);
      for (int d = 0; d < 16; d++) begin
        do_cmd(8'h41, 8'(i), 32'(d));
        do_cmd(8'h51, 8'(i), 0); chk("R3 sel readback", rdata, 32'(d));
        drive(NL'(1) << i);
        chk("R8 R7 fixed deliver", core_irq, place(i, 4'(d)));
        drive(NL'(1) << i);
        chk("R8 fixed held", core_irq, place(i, 4'(d)));
        drive('0);
        chk("R8 fixed drop", core_irq, '0);
      end
    end

    // R5 mask while held, unmask while held
    do_cmd(8'h41, 8'd5, 32'h6);
    drive(8'h20); chk("R5 unmasked", core_irq, place(5, 4'h6));
    do_cmd(8'h43, 8'd5, 32'h1);
    drive(8'h20); chk("R5 masked drops", core_irq, '0);
    do_cmd(8'h53, 8'd5, 0); chk("R5 mask readback", rdata, 32'h1);
    do_cmd(8'h43, 8'd5, 32'h0);
    drive(8'h20); chk("R5 unmask resumes", core_irq, place(5, 4'h6));
    drive('0);

    // R7 all lines at once with distinct masks
    begin
      logic [31:0] e;
      e = '0;
      for (int i = 0; i < NL; i++) begin
        do_cmd(8'h41, 8'(i), 32'((i % 15) + 1));
        e |= place(i, 4'((i % 15) + 1));
      end
      drive('1); chk("R7 all lines", core_irq, e);
      drive('0); chk("R7 all drop", core_irq, '0);
    end

    // R9 rotation sweep
    for (int i = 0; i < NL; i++) begin
      do_cmd(8'h42, 8'(i), 32'h10);
      for (int d = 1; d < 16; d++) begin
        do_cmd(8'h41, 8'(i), 32'(d));
        for (int r = 0; r < 3; r++) rot_hit(i, 4'(d));
      end
    end

    // R11 empty core-select: nothing, pointer unchanged
    do_cmd(8'h41, 8'd2, 32'h0);
    drive(8'h04); chk("R11 empty quiet", core_irq, '0);
    drive('0);
    do_cmd(8'h41, 8'd2, 32'hF);
    rot_hit(2, 4'hF);
    rot_hit(2, 4'hF);

    // R10 edge trigger, fixed then rotating
    do_cmd(8'h42, 8'd6, 32'h02);
    do_cmd(8'h41, 8'd6, 32'h3);
    drive(8'h40); chk("R10 edge pulse", core_irq, place(6, 4'h3));
    drive(8'h40); chk("R10 no repeat", core_irq, '0);
    drive(8'h40); chk("R10 still none", core_irq, '0);
    drive('0);
    do_cmd(8'h42, 8'd6, 32'h00);
    do_cmd(8'h41, 8'd6, 32'hB);
    for (int r = 0; r < 4; r++) begin
      int p;
      logic [NC-1:0] e;
      p = pick(last_idx[6], 4'hB);
      last_idx[6] = p;
      e = '0; e[p] = 1'b1;
      drive(8'h40); chk("R10 edge rotate", core_irq, place(6, e));
      drive(8'h40); chk("R10 edge rotate once", core_irq, '0);
      drive('0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule